// File: doc/BRIEF.md
# Edge Counter with Sixteen-Window Range Comparator

This block counts rising edges on an asynchronous count pin into a four-digit BCD accumulator that runs all the time. The accumulator is never compared directly. When an execute strobe arrives, the block copies it into a present-value register. On the same edge it checks that value against sixteen programmable windows. Each window is a lower and upper limit held in a 32-word table. Each window owns one bit of a 16-bit hit word. Between strobes, the present value and the hit word keep the result of the last comparison.

The accumulator can be cleared in two ways. A soft-clear strobe clears it at once. An external hard-reset pin also clears it, but only when a static enable is high and only after the pin has stayed high for a minimum number of clock cycles. While the qualified hard reset holds, the accumulator stays at zero and count edges are lost. On overflow past 9999 the accumulator either wraps to 0000 or saturates at 9999, as a parameter selects; the default is to wrap.

Top module: `edge_range_counter`

## Requirements
- R1: One low-to-high transition of `cnt_in` adds exactly one to the accumulator. A level held high for many cycles counts once.
- R2: On a clock edge where `exec_stb` is high, `pv_out` takes the accumulator value, with the least significant BCD digit in bits 3:0.
- R3: On the same edge, `hit_out[i]` becomes 1 exactly when lower(i) ≤ value ≤ upper(i), both ends included. A table write at address 2i sets lower(i), and a write at address 2i+1 sets upper(i).
- R4: A window whose lower limit is above its upper limit never sets its hit bit.
- R5: On edges without `exec_stb`, `pv_out` and `hit_out` keep their values. This holds across counting, clears and table writes.
- R6: With `hrst_en` high, once `hrst_in` has been high for `RST_MIN_CYCLES` consecutive synchronized cycles, the accumulator is held at zero and ignores count edges until the pin falls.
- R7: With `hrst_en` low, `hrst_in` has no effect on the count.
- R8: A `hrst_in` pulse shorter than `RST_MIN_CYCLES` cycles leaves the count unchanged.
- R9: A `soft_clr` strobe sets the accumulator to zero.
- R10: With the default wrap mode, one edge at 9999 gives 0000.
- R11: After `rst_n` is released, `pv_out` and `hit_out` are zero.
- R12: Every digit of `pv_out` is a valid BCD digit (0 to 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | 1 | Asynchronous count pin |
| hrst_in | input | 1 | Asynchronous hard-reset pin |
| hrst_en | input | 1 | Static enable for the hard-reset pin |
| soft_clr | input | 1 | Synchronous accumulator clear strobe |
| exec_stb | input | 1 | Latch-and-compare strobe |
| lim_we | input | 1 | Limit table write enable |
| lim_addr | input | 5 | Limit word address (even = lower, odd = upper) |
| lim_wdata | input | 16 | BCD limit value |
| pv_out | output | 16 | Latched present value, BCD |
| hit_out | output | 16 | One bit per window |

## Verification
`pv_out` and `hit_out` change on the very edge that samples `exec_stb`. An edge on `cnt_in` reaches the accumulator on the third clock edge that sees it high: two synchronizer stages, then the counter register. A hard reset takes effect only after the synchronizer delay plus `RST_MIN_CYCLES` cycles. The bench drives every input at the falling edge and leaves four idle cycles after each count burst or reset release before it strobes. It reads the results at the falling edge that follows the strobe, so every pending edge has settled before a value is compared with the bench's own decimal model.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic {
    OVF_WRAP     = 1'b0,
    OVF_SATURATE = 1'b1
  } ovf_mode_e;

  localparam int BCD_DIGIT_W = 4;
endpackage

// File: rtl/erc_sync.sv
module erc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/erc_width_filter.sv
module erc_width_filter #(
  parameter int MIN_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual
);
  localparam int CW = $clog2(MIN_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_CYCLES);

  logic [CW-1:0] run_q;
  logic [CW-1:0] run_n;

  always_comb begin
    if (!raw)               run_n = '0;
    else if (run_q == LIMIT) run_n = run_q;
    else                    run_n = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_n;
  end

  assign qual = (run_q == LIMIT);
endmodule

// File: rtl/erc_bcd_counter.sv
module erc_bcd_counter
  import erc_pkg::*;
#(
  parameter int        DIGITS = 4,
  parameter ovf_mode_e MODE   = OVF_WRAP
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      inc,
  output logic [DIGITS*BCD_DIGIT_W-1:0] value
);
  localparam int W = DIGITS * BCD_DIGIT_W;

  logic [W-1:0]    val_q;
  logic [W-1:0]    stepped;
  logic [W-1:0]    val_n;
  logic [DIGITS:0] carry;

  assign carry[0] = inc;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [BCD_DIGIT_W-1:0] dig;
    assign dig = val_q[g*BCD_DIGIT_W +: BCD_DIGIT_W];
    assign carry[g+1] = carry[g] && (dig == 4'd9);
    always_comb begin
      if (!carry[g])        stepped[g*BCD_DIGIT_W +: BCD_DIGIT_W] = dig;
      else if (dig == 4'd9) stepped[g*BCD_DIGIT_W +: BCD_DIGIT_W] = 4'd0;
      else                  stepped[g*BCD_DIGIT_W +: BCD_DIGIT_W] = dig + 4'd1;
    end
  end

  always_comb begin
    if (clr)                                  val_n = '0;
    else if (carry[DIGITS] && MODE == OVF_SATURATE) val_n = val_q;
    else                                      val_n = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_n;
  end

  assign value = val_q;
endmodule

// File: rtl/erc_range_bank.sv
module erc_range_bank #(
  parameter int PAIRS = 16,
  parameter int W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [$clog2(2*PAIRS)-1:0]  addr,
  input  logic [W-1:0]                wdata,
  input  logic [W-1:0]                probe,
  output logic [PAIRS-1:0]            hits
);
  localparam int AW = $clog2(2 * PAIRS);

  logic [W-1:0] lo_q [PAIRS];
  logic [W-1:0] hi_q [PAIRS];

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic sel_lo;
    logic sel_hi;
    logic [W-1:0] lo_n;
    logic [W-1:0] hi_n;

    assign sel_lo = we && (addr[AW-1:1] == (AW-1)'(p)) && !addr[0];
    assign sel_hi = we && (addr[AW-1:1] == (AW-1)'(p)) &&  addr[0];

    always_comb begin
      lo_n = sel_lo ? wdata : lo_q[p];
      hi_n = sel_hi ? wdata : hi_q[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[p] <= '0;
        hi_q[p] <= '0;
      end else begin
        lo_q[p] <= lo_n;
        hi_q[p] <= hi_n;
      end
    end

    assign hits[p] = (lo_q[p] <= hi_q[p]) && (probe >= lo_q[p]) && (probe <= hi_q[p]);
  end
endmodule

// File: rtl/edge_range_counter.sv
module edge_range_counter
  import erc_pkg::*;
#(
  parameter int        DIGITS         = 4,
  parameter int        NUM_PAIRS      = 16,
  parameter int        SYNC_STAGES    = 2,
  parameter int        RST_MIN_CYCLES = 12500,
  parameter ovf_mode_e OVF_MODE       = OVF_WRAP
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cnt_in,
  input  logic                            hrst_in,
  input  logic                            hrst_en,
  input  logic                            soft_clr,
  input  logic                            exec_stb,
  input  logic                            lim_we,
  input  logic [$clog2(2*NUM_PAIRS)-1:0]  lim_addr,
  input  logic [DIGITS*4-1:0]             lim_wdata,
  output logic [DIGITS*4-1:0]             pv_out,
  output logic [NUM_PAIRS-1:0]            hit_out
);
  localparam int VAL_W = DIGITS * BCD_DIGIT_W;

  logic                 cnt_sync;
  logic                 cnt_prev_q;
  logic                 cnt_rise;
  logic                 hr_sync;
  logic                 hrst_qual;
  logic [VAL_W-1:0]     cnt_q;
  logic [NUM_PAIRS-1:0] win_hits;
  logic [VAL_W-1:0]     pv_q, pv_n;
  logic [NUM_PAIRS-1:0] hit_q, hit_n;

  erc_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .d(cnt_in), .q(cnt_sync)
  );

  erc_sync #(.STAGES(SYNC_STAGES)) u_hr_sync (
    .clk(clk), .rst_n(rst_n), .d(hrst_in), .q(hr_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_prev_q <= 1'b0;
    else        cnt_prev_q <= cnt_sync;
  end

  assign cnt_rise = cnt_sync && !cnt_prev_q;

  erc_width_filter #(.MIN_CYCLES(RST_MIN_CYCLES)) u_hr_filter (
    .clk(clk), .rst_n(rst_n), .raw(hrst_en && hr_sync), .qual(hrst_qual)
  );

  erc_bcd_counter #(.DIGITS(DIGITS), .MODE(OVF_MODE)) u_counter (
    .clk(clk), .rst_n(rst_n),
    .clr(soft_clr || hrst_qual),
    .inc(cnt_rise && !hrst_qual),
    .value(cnt_q)
  );

  erc_range_bank #(.PAIRS(NUM_PAIRS), .W(VAL_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(lim_we), .addr(lim_addr), .wdata(lim_wdata),
    .probe(cnt_q), .hits(win_hits)
  );

  always_comb begin
    pv_n  = exec_stb ? cnt_q    : pv_q;
    hit_n = exec_stb ? win_hits : hit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q  <= '0;
      hit_q <= '0;
    end else begin
      pv_q  <= pv_n;
      hit_q <= hit_n;
    end
  end

  assign pv_out  = pv_q;
  assign hit_out = hit_q;
endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
  parameter int W     = 16,
  parameter int PAIRS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exec_stb,
  input logic             soft_clr,
  input logic             hrst_en,
  input logic [W-1:0]     pv_out,
  input logic [PAIRS-1:0] hit_out,
  input logic [W-1:0]     cnt_val,
  input logic             hrst_qual
);
  // R11: outputs are zero on the first edge after reset release
  assert_reset_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pv_out == '0 && hit_out == '0));

  // R2: an execute strobe copies the accumulator
  assert_pv_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |=> pv_out == $past(cnt_val));

  // R5: outputs hold without a strobe
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_stb |=> ($stable(pv_out) && $stable(hit_out)));

  // R9: soft clear empties the accumulator
  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> cnt_val == '0);

  // R6: qualified hard reset keeps the accumulator at zero
  assert_hard_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hrst_qual |=> cnt_val == '0);

  // R7: disabled hard reset never qualifies
  assert_hr_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hrst_en |=> !hrst_qual);

  // R12: each present-value digit is decimal
  for (genvar g = 0; g < W/4; g++) begin : g_bcd
    assert_bcd_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pv_out[g*4 +: 4] <= 4'd9);
  end
endmodule

bind edge_range_counter erc_checker #(.W(VAL_W), .PAIRS(NUM_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .soft_clr(soft_clr),
  .hrst_en(hrst_en), .pv_out(pv_out), .hit_out(hit_out),
  .cnt_val(cnt_q), .hrst_qual(hrst_qual)
);

// File: tb/edge_range_counter_tb.sv
module edge_range_counter_tb;
  localparam int PAIRS = 16;
  localparam int RMIN  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_in, hrst_in, hrst_en, soft_clr, exec_stb, lim_we;
  logic [4:0]  lim_addr;
  logic [15:0] lim_wdata;
  logic [15:0] pv_out;
  logic [15:0] hit_out;

  int errors = 0;
  int checks = 0;
  int model  = 0;
  logic [15:0] lo_m [PAIRS];
  logic [15:0] hi_m [PAIRS];

  always #10 clk = ~clk;

  edge_range_counter #(.RST_MIN_CYCLES(RMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .hrst_in(hrst_in),
    .hrst_en(hrst_en), .soft_clr(soft_clr), .exec_stb(exec_stb),
    .lim_we(lim_we), .lim_addr(lim_addr), .lim_wdata(lim_wdata),
    .pv_out(pv_out), .hit_out(hit_out)
  );

  function automatic logic [15:0] to_bcd(input int v);
    return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  function automatic logic [15:0] exp_hits(input int v);
    logic [15:0] h;
    logic [15:0] b;
    b = to_bcd(v);
    for (int i = 0; i < PAIRS; i++)
      h[i] = (lo_m[i] <= hi_m[i]) && (b >= lo_m[i]) && (b <= hi_m[i]);
    return h;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_edges(input int n);
    for (int k = 0; k < n; k++) begin
      cnt_in = 1'b1; idle(1);
      cnt_in = 1'b0; idle(1);
    end
    idle(4);
  endtask

  task automatic write_lim(input int addr, input logic [15:0] val);
    lim_we = 1'b1; lim_addr = 5'(addr); lim_wdata = val;
    idle(1);
    lim_we = 1'b0;
  endtask

  task automatic set_pair(input int p, input int lo, input int hi);
    lo_m[p] = to_bcd(lo); hi_m[p] = to_bcd(hi);
    write_lim(2 * p, lo_m[p]);
    write_lim(2 * p + 1, hi_m[p]);
  endtask

  task automatic exec_and_check(input string req);
    exec_stb = 1'b1; idle(1);
    exec_stb = 1'b0;
    check({req, " pv"}, pv_out, to_bcd(model));
    check({req, " hits"}, hit_out, exp_hits(model));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cnt_in = 0; hrst_in = 0; hrst_en = 0; soft_clr = 0;
    exec_stb = 0; lim_we = 0; lim_addr = '0; lim_wdata = '0;
    for (int i = 0; i < PAIRS; i++) begin lo_m[i] = '0; hi_m[i] = '0; end
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    check("R11 pv", pv_out, 16'h0);
    check("R11 hits", hit_out, 16'h0);

    // R3 window table, R4 inverted window at pair 3
    set_pair(0, 0, 5);
    set_pair(1, 3, 3);
    set_pair(2, 10, 20);
    set_pair(3, 7, 2);
    for (int p = 4; p < PAIRS; p++) begin
      int a = int'($urandom_range(0, 40));
      int b = int'($urandom_range(0, 40));
      set_pair(p, a, b);
    end
    // R5 table writes alone leave outputs untouched
    check("R5 pv after writes", pv_out, 16'h0);
    check("R5 hits after writes", hit_out, 16'h0);

    // R1 R2 R3: three edges, boundary of pair 1 (3..3)
    count_edges(3); model = 3;
    exec_and_check("R1 R2 R3 value 3");
    // R4 value 5 lies between upper 2 and lower 7 of pair 3; R3 upper bound pair 0
    count_edges(2); model = 5;
    exec_and_check("R3 R4 value 5");
    // R1 held level counts once
    cnt_in = 1'b1; idle(20); cnt_in = 1'b0; idle(4); model = 6;
    exec_and_check("R1 held level");
    // R5 edges without strobe leave outputs
    count_edges(4); model = 10;
    check("R5 pv hold", pv_out, to_bcd(6));
    check("R5 hits hold", hit_out, exp_hits(6));
    exec_and_check("R3 lower bound 10");

    // R9 soft clear
    soft_clr = 1'b1; idle(1); soft_clr = 1'b0; model = 0;
    exec_and_check("R9 soft clear");

    // R6 qualified hard reset clears and blocks edges
    count_edges(7); model = 7;
    hrst_en = 1'b1; hrst_in = 1'b1; idle(RMIN + 6);
    count_edges(5);
    hrst_in = 1'b0; idle(6); model = 0;
    exec_and_check("R6 hard reset");
    count_edges(2); model = 2;
    exec_and_check("R6 counting resumes");

    // R8 short pulse ignored
    hrst_in = 1'b1; idle(RMIN - 4); hrst_in = 1'b0; idle(6);
    exec_and_check("R8 short pulse");

    // R7 disabled hard reset ignored
    hrst_en = 1'b0; hrst_in = 1'b1; idle(RMIN + 10);
    count_edges(3); model = 5;
    hrst_in = 1'b0; idle(4);
    exec_and_check("R7 disabled reset");

    // random mix
    for (int it = 0; it < 25; it++) begin
      int n = int'($urandom_range(0, 25));
      count_edges(n); model = (model + n) % 10000;
      if ($urandom_range(0, 4) == 0) begin
        soft_clr = 1'b1; idle(1); soft_clr = 1'b0; model = 0;
      end
      exec_and_check("R1 R3 random");
    end

    // R10 wrap at 9999
    soft_clr = 1'b1; idle(1); soft_clr = 1'b0;
    count_edges(9998); model = 9998;
    exec_and_check("R10 near top");
    count_edges(1); model = 9999;
    exec_and_check("R10 at 9999");
    count_edges(1); model = 0;
    exec_and_check("R10 wrap");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule